// File: doc/BRIEF.md
# Read-to-Write Snoop Conversion Wrapper

This block sits between a shared snooping bus and the snoop port of a processor whose cache has only three line states: Modified, Exclusive and Invalid. The same bus also carries a processor whose cache has an additional Shared state. Such a pairing can reach a broken state: a three-state cache moves a line from Exclusive to Modified without any bus traffic, while the four-state cache still holds that line as Shared. The wrapper closes this gap. Every bus read from another master reaches the attached processor as an invalidating (write-type) snoop. As a result, a read never leaves two valid copies of a line behind, and the combined system only uses the states that both protocols have.

The wrapper observes each bus transaction: a valid strobe, an address, a two-bit kind and the master number. It ignores transactions issued by its own processor. For every other transaction it raises one snoop request and holds it until the processor answers. If the snoop hits a Modified line, the wrapper sends a retry to the bus. It then refuses all other traffic until its own processor puts the write-back of that line on the bus, so the original read can only complete after the data has reached memory. If the processor does not answer within a bounded number of cycles, the wrapper drops the request, retries the transaction and sets a sticky error flag.

A parameter selects the conversion. With conversion off, reads are passed as read-type snoops. This variant exists only for comparison.

Top module: `snoop_xlate_wrap`

## Requirements
- R1: While reset is asserted and directly after it, `snp_req_o`, `bus_retry_o` and `snp_err_o` are all 0.
- R2: A read (kind 2'b00) from a master other than `OWN_ID`, seen while the wrapper is idle, raises `snp_req_o` one cycle later. It carries the bus address on `snp_addr_o` and has `snp_inv_o` = 1 (invalidating snoop) when `CONVERT_RD` is 1.
- R3: A write (2'b01), write-back (2'b10) or kind 2'b11 from another master, seen while idle, raises `snp_req_o` one cycle later with `snp_inv_o` = 1 and the bus address.
- R4: A transaction whose master equals `OWN_ID` never starts a snoop.
- R5: While `snp_req_o` is high, `snp_addr_o` and `snp_inv_o` stay unchanged. The request stays high until the cycle in which `snp_ack_i` is sampled high, or until the timeout.
- R6: An answer with `snp_hit_i` and `snp_mod_i` both high drops the request and pulses `bus_retry_o` for one cycle, one cycle after the answer. The wrapper then retries every transaction from other masters and starts no snoop until its own master issues a write-back (2'b10) to the snooped address.
- R7: An answer without a Modified hit drops the request and produces no retry. The wrapper is idle again on the next cycle.
- R8: A transaction from another master that arrives while a snoop is pending is answered with a one-cycle `bus_retry_o` in the next cycle. It does not disturb the pending snoop.
- R9: If no answer arrives within `TIMEOUT` cycles of request, `snp_req_o` falls, `bus_retry_o` pulses and `snp_err_o` goes high and stays high until reset.
- R10: While the wrapper waits for a write-back, an own write-back to a different address, or any own transaction that is not a write-back, does not end the wait.
- R11: In a system of one three-state cache and one four-state cache, each behind its own wrapper, the sequence "peer reads X, own reads X, own writes X silently, peer reads X" never leaves a Modified line in one cache while the other holds a valid copy. The four-state cache never enters Shared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Bus transaction present this cycle |
| bus_addr_i | input | AW | Line address of the transaction |
| bus_kind_i | input | 2 | 00 read, 01 write, 10 write-back, 11 treated as write |
| bus_master_i | input | MW | Number of the issuing master |
| bus_retry_o | output | 1 | One-cycle retry response to the bus |
| snp_req_o | output | 1 | Snoop request to the processor |
| snp_addr_o | output | AW | Snoop address |
| snp_inv_o | output | 1 | 1: invalidating snoop, 0: read snoop |
| snp_ack_i | input | 1 | Processor answer valid |
| snp_hit_i | input | 1 | Snoop hit a valid line |
| snp_mod_i | input | 1 | Hit line was Modified |
| snp_err_o | output | 1 | Sticky snoop timeout flag |

## Verification
A corrupted controller state shows at the ports within one or two cycles. If the wrapper is stuck waiting, the next foreign transaction gets a retry where a snoop request was expected. If it is falsely idle, a foreign transaction during a pending snoop starts no retry, or the snoop address changes. A lost conversion shows at once as `snp_inv_o` low on a read. In the two-cache replay, it shows a few steps later as a Shared copy next to a Modified one. A miscounted timeout moves the fall of the request and the error flag by whole cycles, and the bench counts these cycles exactly.

// File: rtl/snx_pkg.sv
package snx_pkg;
  typedef enum logic [1:0] {
    BUS_RD  = 2'b00,
    BUS_WR  = 2'b01,
    BUS_WB  = 2'b10,
    BUS_RSV = 2'b11
  } bus_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_SNOOP  = 2'b01,
    ST_WBWAIT = 2'b10
  } snx_state_e;
endpackage

// File: rtl/snx_type_map.sv
module snx_type_map
  import snx_pkg::*;
#(
  parameter bit CONVERT_RD = 1'b1
) (
  input  logic [1:0] kind_i,
  output logic       inv_o,
  output logic       wb_o
);
  assign wb_o = (kind_i == BUS_WB);

  generate
    if (CONVERT_RD) begin : g_conv
      // every foreign access invalidates: no line may survive as shared
      assign inv_o = 1'b1;
    end else begin : g_pass
      assign inv_o = (kind_i != BUS_RD);
    end
  endgenerate
endmodule

// File: rtl/snx_timeout.sv
module snx_timeout #(
  parameter int LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int CW = $clog2(LIMIT + 1) + 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/snx_snoop_fsm.sv
module snx_snoop_fsm
  import snx_pkg::*;
#(
  parameter int AW     = 32,
  parameter int MW     = 2,
  parameter int OWN_ID = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_valid_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [MW-1:0] bus_master_i,
  input  logic          bus_wb_i,
  input  logic          inv_i,
  input  logic          snp_ack_i,
  input  logic          mod_hit_i,
  input  logic          expire_i,
  output logic          snp_req_o,
  output logic [AW-1:0] snp_addr_o,
  output logic          snp_inv_o,
  output logic          retry_o,
  output logic          err_o,
  output logic          idle_o,
  output logic          run_o
);
  snx_state_e    state_q;
  logic [AW-1:0] addr_q;
  logic          inv_q, retry_q, err_q;
  logic          foreign, own_wb_match;

  assign foreign      = bus_valid_i && (bus_master_i != MW'(OWN_ID));
  assign own_wb_match = bus_valid_i && !foreign && bus_wb_i && (bus_addr_i == addr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      inv_q   <= 1'b0;
      retry_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      retry_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (foreign) begin
            state_q <= ST_SNOOP;
            addr_q  <= bus_addr_i;
            inv_q   <= inv_i;
          end
        end
        ST_SNOOP: begin
          if (foreign) retry_q <= 1'b1;
          if (snp_ack_i) begin
            if (mod_hit_i) begin
              retry_q <= 1'b1;
              state_q <= ST_WBWAIT;
            end else begin
              state_q <= ST_IDLE;
            end
          end else if (expire_i) begin
            retry_q <= 1'b1;
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_WBWAIT: begin
          // hold off every foreign access until the dirty line is in memory
          if (foreign) retry_q <= 1'b1;
          if (own_wb_match) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign snp_req_o  = (state_q == ST_SNOOP);
  assign snp_addr_o = addr_q;
  assign snp_inv_o  = inv_q;
  assign retry_o    = retry_q;
  assign err_o      = err_q;
  assign idle_o     = (state_q == ST_IDLE);
  assign run_o      = (state_q == ST_SNOOP) && !snp_ack_i;
endmodule

// File: rtl/snoop_xlate_wrap.sv
module snoop_xlate_wrap
  import snx_pkg::*;
#(
  parameter int AW         = 32,
  parameter int MW         = 2,
  parameter int OWN_ID     = 0,
  parameter int TIMEOUT    = 16,
  parameter bit CONVERT_RD = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_valid_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [1:0]    bus_kind_i,
  input  logic [MW-1:0] bus_master_i,
  output logic          bus_retry_o,
  output logic          snp_req_o,
  output logic [AW-1:0] snp_addr_o,
  output logic          snp_inv_o,
  input  logic          snp_ack_i,
  input  logic          snp_hit_i,
  input  logic          snp_mod_i,
  output logic          snp_err_o
);
  logic inv, wb, expire, run, idle, mod_hit;

  assign mod_hit = snp_hit_i && snp_mod_i;

  snx_type_map #(.CONVERT_RD(CONVERT_RD)) u_map (
    .kind_i (bus_kind_i),
    .inv_o  (inv),
    .wb_o   (wb)
  );

  snx_timeout #(.LIMIT(TIMEOUT)) u_tmo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .expire_o (expire)
  );

  snx_snoop_fsm #(.AW(AW), .MW(MW), .OWN_ID(OWN_ID)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bus_valid_i  (bus_valid_i),
    .bus_addr_i   (bus_addr_i),
    .bus_master_i (bus_master_i),
    .bus_wb_i     (wb),
    .inv_i        (inv),
    .snp_ack_i    (snp_ack_i),
    .mod_hit_i    (mod_hit),
    .expire_i     (expire),
    .snp_req_o    (snp_req_o),
    .snp_addr_o   (snp_addr_o),
    .snp_inv_o    (snp_inv_o),
    .retry_o      (bus_retry_o),
    .err_o        (snp_err_o),
    .idle_o       (idle),
    .run_o        (run)
  );
endmodule

// File: rtl/snoop_xlate_wrap_chk.sv
module snoop_xlate_wrap_chk #(
  parameter int AW         = 32,
  parameter int MW         = 2,
  parameter int OWN_ID     = 0,
  parameter int TIMEOUT    = 16,
  parameter bit CONVERT_RD = 1'b1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_valid_i,
  input logic [AW-1:0] bus_addr_i,
  input logic [1:0]    bus_kind_i,
  input logic [MW-1:0] bus_master_i,
  input logic          bus_retry_o,
  input logic          snp_req_o,
  input logic [AW-1:0] snp_addr_o,
  input logic          snp_inv_o,
  input logic          snp_ack_i,
  input logic          snp_hit_i,
  input logic          snp_mod_i,
  input logic          snp_err_o,
  input logic          idle
);
  localparam int CW = $clog2(TIMEOUT + 1) + 1;

  logic          foreign;
  logic [CW-1:0] wait_cnt;

  assign foreign = bus_valid_i && (bus_master_i != MW'(OWN_ID));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      wait_cnt <= '0;
    else if (snp_req_o && !snp_ack_i) wait_cnt <= wait_cnt + 1'b1;
    else                              wait_cnt <= '0;
  end

  // R2
  read_convert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle && foreign && bus_kind_i == 2'b00 |=>
      snp_req_o && snp_inv_o == CONVERT_RD && snp_addr_o == $past(bus_addr_i));

  // R3
  write_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle && foreign && bus_kind_i != 2'b00 |=> snp_req_o && snp_inv_o);

  // R4
  own_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle && bus_valid_i && !foreign |=> !snp_req_o);

  // R5
  req_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_req_o && $past(snp_req_o) && !$past(snp_ack_i) |->
      $stable(snp_addr_o) && $stable(snp_inv_o));

  // R6
  mod_retry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_req_o && snp_ack_i && snp_hit_i && snp_mod_i |=> bus_retry_o && !snp_req_o);

  // R7
  clean_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_req_o && snp_ack_i && !snp_mod_i && !foreign |=> !bus_retry_o && idle);

  // R8
  busy_retry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_req_o && foreign |=> bus_retry_o);

  // R9
  wait_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_req_o |-> wait_cnt < CW'(TIMEOUT));

  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_err_o |=> snp_err_o);
endmodule

bind snoop_xlate_wrap snoop_xlate_wrap_chk #(
  .AW(AW), .MW(MW), .OWN_ID(OWN_ID), .TIMEOUT(TIMEOUT), .CONVERT_RD(CONVERT_RD)
) u_chk (.*);

// File: tb/snoop_xlate_wrap_tb.sv
module snoop_xlate_wrap_tb;
  localparam int AW  = 8;
  localparam int MW  = 2;
  localparam int TMO = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_valid = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [1:0]    bus_kind = 2'b00;
  logic [MW-1:0] bus_master = '0;
  logic          d_retry, d_req, d_inv, d_err;
  logic [AW-1:0] d_addr;
  logic          d_ack = 1'b0, d_hit = 1'b0, d_mod = 1'b0;
  logic          p_retry, p_req, p_inv, p_err;
  logic [AW-1:0] p_addr;
  logic [1:0]    mei_st = 2'd0, mesi_st = 2'd0;  // 0 I, 1 S, 2 E, 3 M
  int            n_chk = 0, n_fail = 0;
  bit            done = 1'b0;

  always #2 clk = ~clk;

  snoop_xlate_wrap #(.AW(AW), .MW(MW), .OWN_ID(0), .TIMEOUT(TMO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(bus_valid), .bus_addr_i(bus_addr),
    .bus_kind_i(bus_kind), .bus_master_i(bus_master), .bus_retry_o(d_retry),
    .snp_req_o(d_req), .snp_addr_o(d_addr), .snp_inv_o(d_inv),
    .snp_ack_i(d_ack), .snp_hit_i(d_hit), .snp_mod_i(d_mod), .snp_err_o(d_err));

  // peer wrapper in front of the four-state cache; answers at once
  snoop_xlate_wrap #(.AW(AW), .MW(MW), .OWN_ID(1), .TIMEOUT(TMO)) u_peer (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(bus_valid), .bus_addr_i(bus_addr),
    .bus_kind_i(bus_kind), .bus_master_i(bus_master), .bus_retry_o(p_retry),
    .snp_req_o(p_req), .snp_addr_o(p_addr), .snp_inv_o(p_inv),
    .snp_ack_i(p_req), .snp_hit_i(mesi_st != 2'd0), .snp_mod_i(mesi_st == 2'd3),
    .snp_err_o(p_err));

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] k, input logic [AW-1:0] a, input int m);
    @(negedge clk);
    bus_valid = 1'b1; bus_kind = k; bus_addr = a; bus_master = MW'(m);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic answer(input logic h, input logic md);
    d_ack = 1'b1; d_hit = h; d_mod = md;
    @(negedge clk);
    d_ack = 1'b0; d_hit = 1'b0; d_mod = 1'b0;
  endtask

  task automatic coherent();
    chk("R11 no dirty line beside a copy",
        64'((mei_st == 2'd3 && mesi_st != 2'd0) || (mesi_st == 2'd3 && mei_st != 2'd0)), 64'd0);
    chk("R11 no shared state", 64'(mesi_st == 2'd1), 64'd0);
  endtask

  // one bus step through both wrappers and both cache models
  task automatic step(input logic [1:0] k, input logic [AW-1:0] a, input int m,
                      input logic exp_rty);
    logic dq, di, pq, pi, rty;
    drive(k, a, m);
    dq = d_req; di = d_inv; pq = p_req; pi = p_inv;
    if (dq) begin
      d_ack = 1'b1; d_hit = (mei_st != 2'd0); d_mod = (mei_st == 2'd3);
    end
    @(negedge clk);
    d_ack = 1'b0; d_hit = 1'b0; d_mod = 1'b0;
    rty = d_retry | p_retry;
    chk("R11 retry on dirty hit", 64'(rty), 64'(exp_rty));
    if (dq && di) mei_st = 2'd0;
    if (pq && pi) mesi_st = 2'd0;
    if (pq && !pi && mesi_st != 2'd0) mesi_st = 2'd1;
    if (!rty) begin
      if (k == 2'b00 && m == 0) mei_st = 2'd2;
      if (k == 2'b00 && m == 1) mesi_st = (mei_st != 2'd0) ? 2'd1 : 2'd2;
      if (k == 2'b01 && m == 0) mei_st = 2'd3;
      if (k == 2'b01 && m == 1) mesi_st = 2'd3;
    end
    coherent();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 req in reset", 64'(d_req), 64'd0);
    chk("R1 retry in reset", 64'(d_retry), 64'd0);
    chk("R1 err in reset", 64'(d_err), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req after reset", 64'(d_req), 64'd0);

    // sweep of kind x master x answer
    for (int k = 0; k < 4; k++)
      for (int m = 0; m < 4; m++)
        for (int r = 0; r < 3; r++) begin
          logic [AW-1:0] a = AW'(8'h40 + k * 12 + m * 3 + r);
          drive(2'(k), a, m);
          if (m == 0) begin
            chk("R4 own txn not snooped", 64'(d_req), 64'd0);
          end else begin
            chk(k == 0 ? "R2 read snooped" : "R3 write snooped", 64'(d_req), 64'd1);
            chk(k == 0 ? "R2 read converted" : "R3 write invalidates", 64'(d_inv), 64'd1);
            chk("R2 R3 snoop address", 64'(d_addr), 64'(a));
            answer(r != 0, r == 2);
            chk(r == 2 ? "R6 retry on dirty hit" : "R7 no retry", 64'(d_retry), 64'(r == 2));
            chk("R6 R7 req drops", 64'(d_req), 64'd0);
            if (r == 2) begin
              drive(2'b10, a, 0);
              chk("R6 write-back not snooped", 64'(d_req), 64'd0);
              chk("R6 write-back not retried", 64'(d_retry), 64'd0);
            end
          end
        end

    // R8: foreign access while a snoop is pending
    drive(2'b00, 8'h11, 2);
    chk("R8 first snoop up", 64'(d_req), 64'd1);
    drive(2'b01, 8'h22, 3);
    chk("R8 busy retry", 64'(d_retry), 64'd1);
    chk("R5 addr held", 64'(d_addr), 64'h11);
    chk("R5 req held", 64'(d_req), 64'd1);
    answer(1'b0, 1'b0);
    chk("R8 R7 retry cleared", 64'(d_retry), 64'd0);
    chk("R7 idle after miss", 64'(d_req), 64'd0);

    // R10: write-back wait survives unrelated own traffic
    drive(2'b00, 8'h33, 1);
    answer(1'b1, 1'b1);
    chk("R6 dirty hit retry", 64'(d_retry), 64'd1);
    drive(2'b10, 8'h34, 0);
    drive(2'b00, 8'h33, 0);
    drive(2'b00, 8'h33, 1);
    chk("R10 still waiting retry", 64'(d_retry), 64'd1);
    chk("R10 no snoop while waiting", 64'(d_req), 64'd0);
    drive(2'b10, 8'h33, 0);
    drive(2'b00, 8'h33, 1);
    chk("R6 released after write-back", 64'(d_req), 64'd1);
    answer(1'b0, 1'b0);
    chk("R9 no error yet", 64'(d_err), 64'd0);

    // R11: two-cache replay on line X
    step(2'b00, 8'h5A, 1, 1'b0);
    chk("R11 peer exclusive", 64'(mesi_st), 64'd2);
    step(2'b00, 8'h5A, 0, 1'b0);
    chk("R11 own exclusive, peer dropped", 64'({mei_st, mesi_st}), 64'({2'd2, 2'd0}));
    mei_st = 2'd3;  // silent upgrade of an exclusive line
    coherent();
    step(2'b00, 8'h5A, 1, 1'b1);
    chk("R11 dirty line invalidated", 64'(mei_st), 64'd0);
    step(2'b10, 8'h5A, 0, 1'b0);
    step(2'b00, 8'h5A, 1, 1'b0);
    chk("R11 peer gets clean exclusive", 64'({mei_st, mesi_st}), 64'({2'd0, 2'd2}));

    // R9: timeout
    drive(2'b01, 8'h77, 2);
    chk("R9 snoop up", 64'(d_req), 64'd1);
    for (int c = 1; c < TMO; c++) begin
      @(negedge clk);
      if (c == TMO - 1) chk("R9 req held until limit", 64'(d_req), 64'd1);
    end
    @(negedge clk);
    chk("R9 req dropped", 64'(d_req), 64'd0);
    chk("R9 retry on timeout", 64'(d_retry), 64'd1);
    chk("R9 error set", 64'(d_err), 64'd1);
    @(negedge clk);
    chk("R9 retry one cycle", 64'(d_retry), 64'd0);
    chk("R9 error sticky", 64'(d_err), 64'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule